// File: doc/BRIEF.md
# Relative Branch Target Sequencer with Page Fix-Up

This block resolves a relative branch on a machine whose program counter is split into an 8-bit page byte (high) and an 8-bit offset byte (low). A signed displacement is added to the offset byte only. The block then drives a short run of fetch addresses toward memory, one per accepted handshake. The first fetch goes to the sequential address. The second goes to the old page with the new offset. A third fetch, with the corrected page, is issued only when the branch left its page, whether by carry upward or by borrow downward.

The caller presents the address of the instruction after the branch, the displacement, a taken flag and a page-fix enable, and pulses `start`. The sequencer captures these values, runs its fetches under the `fetch_ready` handshake, and ends with a one-cycle `done` pulse carrying the final page and offset bytes.

States: `ST_IDLE` (waiting for `start`), `ST_SEQ` (sequential fetch), `ST_TGT` (old page with new offset), `ST_FIX` (corrected page with new offset). Transitions: IDLE→SEQ on `start`. SEQ→TGT when the fetch is accepted and the branch is taken. SEQ→IDLE when the fetch is accepted and the branch is not taken. TGT→FIX when the fetch is accepted and the page was crossed. TGT→IDLE when the fetch is accepted and the page was not crossed. FIX→IDLE when the fetch is accepted.

Top module: `branch_page_seq`

## Requirements
- R1: The new offset byte is the low 8 bits of the unsigned offset byte plus the displacement read as signed two's complement.
- R2: With page fix enabled, a displacement with bit 7 clear whose addition carries out of bit 7 makes the final page byte one larger, modulo 256 (offset 254 plus 20 gives offset 18 and page+1).
- R3: With page fix enabled, a displacement with bit 7 set whose addition gives no carry out of bit 7 makes the final page byte one smaller, modulo 256 (offset 0 plus -20 gives offset 236 and page-1).
- R4: Page crossing is judged from the carry out of bit 7 and the displacement sign, not from the sign of the truncated sum: offset 0x7F plus 0x7F gives offset 0xFE with the page unchanged and no third fetch.
- R5: For a taken branch, the first fetch address is {page_in, offset_in} and the second is {page_in, new offset}.
- R6: A third fetch {corrected page, new offset} is issued only when R2 or R3 applies. Otherwise the sequence ends after the second fetch.
- R7: With page fix disabled, the final page byte equals the input page byte and no third fetch is issued, whatever the offset result.
- R8: For a branch that is not taken, only the sequential fetch is issued and the final bytes equal the input bytes.
- R9: A fetch advances only on a cycle with `fetch_valid` and `fetch_ready` both high. While it waits, `fetch_addr` holds steady.
- R10: Synchronous active-high reset returns the block to idle with `fetch_valid` and `done` low.
- R11: `done` is high for exactly the one cycle after the last fetch is accepted. `pc_hi_out` and `pc_lo_out` carry the final bytes from that cycle until the next sequence ends.
- R12: `start` and the branch inputs are ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a branch sequence (accepted in idle only) |
| taken | input | 1 | Branch is taken |
| fix_en | input | 1 | Enable page-byte correction |
| pc_hi_in | input | 8 | Page byte of the sequential address |
| pc_lo_in | input | 8 | Offset byte of the sequential address |
| disp | input | 8 | Signed two's-complement displacement |
| fetch_ready | input | 1 | Memory accepts the current fetch |
| fetch_valid | output | 1 | A fetch address is presented |
| fetch_addr | output | 16 | Fetch address, page byte in the upper half |
| done | output | 1 | One-cycle completion pulse |
| pc_hi_out | output | 8 | Final page byte |
| pc_lo_out | output | 8 | Final offset byte |

## Verification
The assertions assume that `fetch_ready` is only meaningful while `fetch_valid` is high, and that the branch inputs need only be valid in the cycle `start` is sampled in idle. They also assume that reset is held for at least one clock before the first `start`. The stimulus pulses `start` only from idle, except for deliberate pokes made mid-sequence with scrambled inputs. It drops `fetch_ready` at random so that stalls of varying length occur. It holds reset for several cycles at power-up.

// File: rtl/branch_seq_pkg.sv
package branch_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEQ  = 2'd1,
        ST_TGT  = 2'd2,
        ST_FIX  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } page_step_t;

endpackage

// File: rtl/bps_offset_add.sv
module bps_offset_add
    import branch_seq_pkg::*;
#(
    parameter int HI_W = 8,
    parameter int LO_W = 8
) (
    input  logic [HI_W-1:0] hi,
    input  logic [LO_W-1:0] lo,
    input  logic [LO_W-1:0] disp,
    input  logic            en,
    output logic [HI_W-1:0] hi_new,
    output logic [LO_W-1:0] lo_new,
    output logic            crossed
);
    localparam int PC_W = HI_W + LO_W;

    logic [LO_W:0] sum_ext;
    logic          carry;
    logic          neg;
    page_step_t    step;

    always_comb begin
        sum_ext = {1'b0, lo} + {1'b0, disp};
        carry   = sum_ext[LO_W];
        neg     = disp[LO_W-1];
        lo_new  = sum_ext[LO_W-1:0];
        if (!en) begin
            step = STEP_NONE;
        end else if (!neg && carry) begin
            step = STEP_UP;
        end else if (neg && !carry) begin
            step = STEP_DOWN;
        end else begin
            step = STEP_NONE;
        end
        unique case (step)
            STEP_UP:   hi_new = hi + 1'b1;
            STEP_DOWN: hi_new = hi - 1'b1;
            default:   hi_new = hi;
        endcase
        crossed = (step != STEP_NONE);
    end

    // With correction on, the full 16-bit target must equal old PC plus sign-extended displacement.
    logic [PC_W-1:0] pc_delta;
    logic [PC_W-1:0] disp_sext;
    always_comb begin
        pc_delta  = {hi_new, lo_new} - {hi, lo};
        disp_sext = {{HI_W{disp[LO_W-1]}}, disp};
        if (en === 1'b1) begin
            a_r2_r3_page_arith: assert (pc_delta == disp_sext)
                else $error("page arithmetic mismatch");
        end
    end

endmodule

// File: rtl/bps_seq_fsm.sv
module bps_seq_fsm
    import branch_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       taken_q,
    input  logic       crossed,
    input  logic       fetch_ready,
    output seq_state_t state,
    output logic       fetch_valid,
    output logic       capture,
    output logic       last_accept,
    output logic       done
);
    seq_state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            state <= state_nx;
            done  <= last_accept;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_SEQ;
            ST_SEQ:  if (fetch_ready) state_nx = taken_q ? ST_TGT : ST_IDLE;
            ST_TGT:  if (fetch_ready) state_nx = crossed ? ST_FIX : ST_IDLE;
            ST_FIX:  if (fetch_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        fetch_valid = (state != ST_IDLE);
        capture     = (state == ST_IDLE) && start;
        unique case (state)
            ST_SEQ:  last_accept = fetch_ready && !taken_q;
            ST_TGT:  last_accept = fetch_ready && !crossed;
            ST_FIX:  last_accept = fetch_ready;
            default: last_accept = 1'b0;
        endcase
    end

    // R10: reset leaves the sequencer quiet
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (!fetch_valid && !done));

    // R11: done is a single-cycle pulse following an accepted fetch
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r11_done_after_accept: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(fetch_valid && fetch_ready));

    // R6: the fix-up fetch only exists when the adder reported a crossing
    a_r6_fix_only_on_cross: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIX) |-> crossed);

    // R12: a busy sequencer never re-enters the sequential fetch from a new start
    a_r12_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !fetch_ready && start) |=> (state == $past(state)));

endmodule

// File: rtl/branch_page_seq.sv
module branch_page_seq
    import branch_seq_pkg::*;
#(
    parameter int HI_W = 8,
    parameter int LO_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 taken,
    input  logic                 fix_en,
    input  logic [HI_W-1:0]      pc_hi_in,
    input  logic [LO_W-1:0]      pc_lo_in,
    input  logic [LO_W-1:0]      disp,
    input  logic                 fetch_ready,
    output logic                 fetch_valid,
    output logic [HI_W+LO_W-1:0] fetch_addr,
    output logic                 done,
    output logic [HI_W-1:0]      pc_hi_out,
    output logic [LO_W-1:0]      pc_lo_out
);
    localparam int PC_W = HI_W + LO_W;

    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] lo_q;
    logic [LO_W-1:0] disp_q;
    logic            en_q;
    logic            taken_q;
    logic [HI_W-1:0] hi_new;
    logic [LO_W-1:0] lo_new;
    logic            crossed;
    logic            capture;
    logic            last_accept;
    seq_state_t      state;

    bps_offset_add #(.HI_W(HI_W), .LO_W(LO_W)) add_i (
        .hi      (hi_q),
        .lo      (lo_q),
        .disp    (disp_q),
        .en      (en_q),
        .hi_new  (hi_new),
        .lo_new  (lo_new),
        .crossed (crossed)
    );

    bps_seq_fsm fsm_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .taken_q     (taken_q),
        .crossed     (crossed),
        .fetch_ready (fetch_ready),
        .state       (state),
        .fetch_valid (fetch_valid),
        .capture     (capture),
        .last_accept (last_accept),
        .done        (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q      <= '0;
            lo_q      <= '0;
            disp_q    <= '0;
            en_q      <= 1'b0;
            taken_q   <= 1'b0;
            pc_hi_out <= '0;
            pc_lo_out <= '0;
        end else begin
            if (capture) begin
                hi_q    <= pc_hi_in;
                lo_q    <= pc_lo_in;
                disp_q  <= disp;
                en_q    <= fix_en;
                taken_q <= taken;
            end
            if (last_accept) begin
                pc_hi_out <= taken_q ? hi_new : hi_q;
                pc_lo_out <= taken_q ? lo_new : lo_q;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_SEQ:  fetch_addr = {hi_q, lo_q};
            ST_TGT:  fetch_addr = {hi_q, lo_new};
            ST_FIX:  fetch_addr = {hi_new, lo_new};
            default: fetch_addr = '0;
        endcase
    end

    // R9: a stalled fetch keeps its address
    a_r9_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

    // R7: with correction off the fix-up fetch never appears
    a_r7_no_fix_when_off: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !en_q) |-> (state != ST_FIX));

endmodule

// File: tb/branch_page_seq_tb_top.sv
module branch_page_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        taken = 1'b0;
    logic        fix_en = 1'b0;
    logic [7:0]  pc_hi_in = '0;
    logic [7:0]  pc_lo_in = '0;
    logic [7:0]  disp = '0;
    logic        fetch_ready = 1'b0;
    logic        fetch_valid;
    logic [15:0] fetch_addr;
    logic        done;
    logic [7:0]  pc_hi_out;
    logic [7:0]  pc_lo_out;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    branch_page_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .taken(taken), .fix_en(fix_en),
        .pc_hi_in(pc_hi_in), .pc_lo_in(pc_lo_in), .disp(disp),
        .fetch_ready(fetch_ready), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .done(done),
        .pc_hi_out(pc_hi_out), .pc_lo_out(pc_lo_out)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] model(input logic [7:0] h, input logic [7:0] l,
                                          input logic [7:0] d, input bit en);
        logic [8:0] s;
        logic [7:0] nh;
        bit cr;
        s  = {1'b0, l} + {1'b0, d};
        nh = h;
        cr = 1'b0;
        if (en && !d[7] && s[8]) begin nh = h + 8'd1; cr = 1'b1; end
        if (en && d[7] && !s[8]) begin nh = h - 8'd1; cr = 1'b1; end
        return {cr, nh, s[7:0]};
    endfunction

    task automatic run_branch(input logic [7:0] h, input logic [7:0] l, input logic [7:0] d,
                              input bit tk, input bit en, input bit poke, input string ftag);
        logic [16:0] m;
        logic [15:0] exp_a [3];
        logic [15:0] fin;
        int n;
        int idx;
        bit prev_acc;
        m = model(h, l, d, en);
        exp_a[0] = {h, l};
        exp_a[1] = {h, m[7:0]};
        exp_a[2] = m[15:0];
        n = !tk ? 1 : (m[16] ? 3 : 2);
        fin = tk ? m[15:0] : {h, l};
        @(negedge clk);
        pc_hi_in = h; pc_lo_in = l; disp = d; taken = tk; fix_en = en; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx = 0;
        prev_acc = 1'b1;
        for (int g = 0; g < 200 && idx < n; g++) begin
            if (poke && g == 0) begin
                start = 1'b1; pc_hi_in = ~h; pc_lo_in = ~l; disp = ~d; taken = ~tk; fix_en = ~en;
            end else begin
                start = 1'b0;
            end
            check(fetch_valid === 1'b1 && fetch_addr === exp_a[idx],
                  poke ? "R12" : (!prev_acc ? "R9" : (idx == 2 ? "R6" : "R5")),
                  {fetch_valid, fetch_addr}, {1'b1, exp_a[idx]});
            check(done === 1'b0, "R11", done, 0);
            fetch_ready = (poke && g == 0) ? 1'b0 : (($urandom % 3) != 0);
            prev_acc = fetch_ready;
            @(negedge clk);
            if (prev_acc) idx++;
        end
        fetch_ready = 1'b0;
        start = 1'b0;
        check(done === 1'b1 && fetch_valid === 1'b0, "R11", {done, fetch_valid}, 2'b10);
        check({pc_hi_out, pc_lo_out} === fin, ftag, {pc_hi_out, pc_lo_out}, fin);
        @(negedge clk);
        check(done === 1'b0 && {pc_hi_out, pc_lo_out} === fin, "R11",
              {done, pc_hi_out, pc_lo_out}, {1'b0, fin});
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        check(fetch_valid === 1'b0 && done === 1'b0, "R10", {fetch_valid, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(fetch_valid === 1'b0 && done === 1'b0, "R10", {fetch_valid, done}, 0);

        run_branch(8'h40, 8'd254, 8'd20,  1, 1, 0, "R2");
        run_branch(8'h40, 8'd0,   8'hEC,  1, 1, 0, "R3");
        run_branch(8'h12, 8'h7F,  8'h7F,  1, 1, 0, "R4");
        run_branch(8'hFF, 8'hF0,  8'h20,  1, 1, 0, "R2");
        run_branch(8'h00, 8'h05,  8'h80,  1, 1, 0, "R3");
        run_branch(8'h33, 8'hF0,  8'h30,  1, 0, 0, "R7");
        run_branch(8'h33, 8'h01,  8'hF0,  1, 0, 0, "R7");
        run_branch(8'h21, 8'h10,  8'hEE,  1, 1, 0, "R1");
        run_branch(8'h55, 8'hFE,  8'h04,  0, 1, 0, "R8");
        run_branch(8'h44, 8'hFE,  8'h10,  1, 1, 1, "R12");

        for (int k = 0; k < 400; k++) begin
            run_branch($urandom, $urandom, $urandom, ($urandom % 4) != 0,
                       ($urandom % 5) != 0, ($urandom % 10) == 0, "R1");
        end

        rst = 1'b1;
        @(negedge clk);
        check(fetch_valid === 1'b0 && done === 1'b0, "R10", {fetch_valid, done}, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule